// File: doc/BRIEF.md
# Security-Banked System Control Register Block

This block holds a processor core's system control word and its auxiliary control word. Each access request states which register it targets, whether it reads or writes, the write data, and the privilege and security state it runs under. The block decides whether the access is allowed, filters the write data bit by bit, and updates the right copy of each bit. One clock cycle later it answers with read data, a write-accepted flag and an undefined-instruction fault.

The low three bits of the control word each have a secure copy and a non-secure copy. These bits are translation enable, strict alignment checking and data caching. The enable outputs always show the copy that belongs to the current security state.

Three parameter masks pick which control bits are banked, which bits only secure software may change, and which bits are fixed. The auxiliary word is a single copy shared by both states. Non-secure software may write it only when a permission input allows this.

Top module: `sysctl_bank`

## Requirements
- R1: Any access to either register with `cur_priv` = 0 raises `rsp_fault`, returns `rsp_wr_ok` = 0 and changes no stored bit.
- R2: A control-word write (`req_sel` = 0) from secure privileged state while `sec_disable` = 1 faults and leaves every stored control bit unchanged. Reads in that case do not fault.
- R3: A non-secure privileged control write is accepted (`rsp_wr_ok` = 1, no fault), but it leaves the bits in `CTL_SMO_MASK` unchanged. All other writable bits of the same write take the new data.
- R4: A non-secure read returns the secure copy for the bits in `CTL_SMO_MASK`.
- R5: Bits in `CTL_RO_MASK` and `AUX_RO_MASK` keep their reset value through every write in every state.
- R6: Control bits 0 (translate), 1 (align) and 2 (data cache) are banked. Each resets to 0, and a write from one state never changes the copy that the other state reads.
- R7: `en_translate`, `en_align` and `en_dcache` show bits 0, 1 and 2 of the copy that matches `cur_nonsec`. They follow a change of `cur_nonsec` with no clock edge in between.
- R8: The auxiliary word (`req_sel` = 1) is one copy that both states read. A secure privileged write updates every bit outside `AUX_RO_MASK`.
- R9: A non-secure privileged auxiliary write with `ns_aux_allow` = 0 is ignored: no fault and `rsp_wr_ok` = 0. With `ns_aux_allow` = 1 it is accepted like a secure write.
- R10: `rsp_valid` pulses for exactly one cycle, on the cycle after each `req_valid`. `rsp_fault` and `rsp_wr_ok` are high only during that pulse.
- R11: After reset the control word reads `CTL_RESET` in both states, the auxiliary word reads `AUX_RESET`, and `rsp_rdata` is 0 on writes and faulted accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_sel | input | 1 | 0 selects the control word, 1 selects the auxiliary word |
| req_write | input | 1 | 1 means write, 0 means read |
| req_wdata | input | DW | Write data |
| cur_priv | input | 1 | 1 for privileged execution |
| cur_nonsec | input | 1 | 1 for non-secure state |
| sec_disable | input | 1 | Locks secure control-word writes |
| ns_aux_allow | input | 1 | Lets non-secure software write the auxiliary word |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | DW | Read data |
| rsp_wr_ok | output | 1 | Write was performed |
| rsp_fault | output | 1 | Undefined-instruction fault |
| en_translate | output | 1 | Address translation enable for the current state |
| en_align | output | 1 | Strict alignment check enable for the current state |
| en_dcache | output | 1 | Data cache enable for the current state |

## Verification
The control word is written under all eight combinations of privilege, security state and the disable pin, using a different data pattern each time. After every write, the word is read back from both states. This separates user-mode faults, the secure lock, the non-secure per-bit filter and bank crossover.

Writes of all-ones and all-zeros expose fixed bits that move and secure-only bits that leak through from non-secure writes. Setting opposite patterns in the two banks and then toggling the security state without a clock shows whether the enable outputs pick the right copy. The auxiliary word is tried with the permission bit both low and high, to tell an ignored write from an accepted one.

// File: rtl/sysctl_bank_pkg.sv
package sysctl_bank_pkg;

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_AUX = 1'b1
    } reg_sel_e;

    localparam int unsigned BIT_TRANSLATE = 0;
    localparam int unsigned BIT_ALIGN     = 1;
    localparam int unsigned BIT_DCACHE    = 2;

endpackage

// File: rtl/sysctl_gate.sv
module sysctl_gate
    import sysctl_bank_pkg::*;
(
    input  logic     write_i,
    input  reg_sel_e sel_i,
    input  logic     priv_i,
    input  logic     nonsec_i,
    input  logic     sec_disable_i,
    input  logic     ns_aux_allow_i,
    output logic     fault_o,
    output logic     wr_ok_o
);
    logic lock_hit;
    logic aux_ro_hit;

    always_comb begin
        lock_hit   = (sel_i == SEL_CTL) && write_i && !nonsec_i && sec_disable_i;
        aux_ro_hit = (sel_i == SEL_AUX) && nonsec_i && !ns_aux_allow_i;
        fault_o    = !priv_i || lock_hit;
        wr_ok_o    = write_i && !fault_o && !aux_ro_hit;
    end
endmodule

// File: rtl/sysctl_view.sv
module sysctl_view #(
    parameter int unsigned    DW        = 32,
    parameter logic [DW-1:0]  BANK_MASK = '0,
    parameter logic [DW-1:0]  SMO_MASK  = '0
) (
    input  logic [DW-1:0] s_word_i,
    input  logic [DW-1:0] ns_word_i,
    input  logic          nonsec_i,
    output logic [DW-1:0] view_o
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (BANK_MASK[i] && !SMO_MASK[i]) begin : g_banked
            assign view_o[i] = nonsec_i ? ns_word_i[i] : s_word_i[i];
        end else begin : g_shared
            assign view_o[i] = s_word_i[i];
        end
    end
endmodule

// File: rtl/sysctl_merge.sv
module sysctl_merge #(
    parameter int unsigned    DW        = 32,
    parameter logic [DW-1:0]  BANK_MASK = '0,
    parameter logic [DW-1:0]  SMO_MASK  = '0,
    parameter logic [DW-1:0]  RO_MASK   = '0
) (
    input  logic [DW-1:0] s_q_i,
    input  logic [DW-1:0] ns_q_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          nonsec_i,
    output logic [DW-1:0] s_d_o,
    output logic [DW-1:0] ns_d_o
);
    localparam logic [DW-1:0] SEC_WMASK = ~RO_MASK;
    localparam logic [DW-1:0] NS_WMASK  = ~RO_MASK & ~SMO_MASK;
    localparam logic [DW-1:0] NS_BANKED = NS_WMASK & BANK_MASK;
    localparam logic [DW-1:0] NS_SHARED = NS_WMASK & ~BANK_MASK;

    always_comb begin
        if (nonsec_i) begin
            s_d_o  = (s_q_i & ~NS_SHARED) | (wdata_i & NS_SHARED);
            ns_d_o = (ns_q_i & ~NS_BANKED) | (wdata_i & NS_BANKED);
        end else begin
            s_d_o  = (s_q_i & ~SEC_WMASK) | (wdata_i & SEC_WMASK);
            ns_d_o = ns_q_i;
        end
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_bank_pkg::*;
#(
    parameter int unsigned    DW           = 32,
    parameter logic [DW-1:0]  CTL_BANK_MASK = 32'h0000_0007,
    parameter logic [DW-1:0]  CTL_SMO_MASK  = 32'h0000_2100,
    parameter logic [DW-1:0]  CTL_RO_MASK   = 32'h0000_0078,
    parameter logic [DW-1:0]  CTL_RESET     = 32'h0000_0050,
    parameter logic [DW-1:0]  AUX_RO_MASK   = 32'hFFFF_FF80,
    parameter logic [DW-1:0]  AUX_RESET     = 32'h0000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_sel,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    input  logic          cur_priv,
    input  logic          cur_nonsec,
    input  logic          sec_disable,
    input  logic          ns_aux_allow,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_wr_ok,
    output logic          rsp_fault,
    output logic          en_translate,
    output logic          en_align,
    output logic          en_dcache
);
    typedef struct packed {
        logic [DW-1:0] ctl_s;
        logic [DW-1:0] ctl_ns;
        logic [DW-1:0] aux;
        logic          rsp_valid;
        logic          rsp_fault;
        logic          rsp_wr_ok;
        logic [DW-1:0] rsp_rdata;
    } state_t;

    state_t st_d, st_q;
    reg_sel_e      sel;
    logic          g_fault, g_wr_ok;
    logic [DW-1:0] ctl_view;
    logic [DW-1:0] ctl_s_new, ctl_ns_new;

    assign sel = reg_sel_e'(req_sel);

    sysctl_gate i_gate (
        .write_i       (req_write),
        .sel_i         (sel),
        .priv_i        (cur_priv),
        .nonsec_i      (cur_nonsec),
        .sec_disable_i (sec_disable),
        .ns_aux_allow_i(ns_aux_allow),
        .fault_o       (g_fault),
        .wr_ok_o       (g_wr_ok)
    );

    sysctl_view #(.DW(DW), .BANK_MASK(CTL_BANK_MASK), .SMO_MASK(CTL_SMO_MASK)) i_view (
        .s_word_i (st_q.ctl_s),
        .ns_word_i(st_q.ctl_ns),
        .nonsec_i (cur_nonsec),
        .view_o   (ctl_view)
    );

    sysctl_merge #(.DW(DW), .BANK_MASK(CTL_BANK_MASK), .SMO_MASK(CTL_SMO_MASK),
                   .RO_MASK(CTL_RO_MASK)) i_merge (
        .s_q_i   (st_q.ctl_s),
        .ns_q_i  (st_q.ctl_ns),
        .wdata_i (req_wdata),
        .nonsec_i(cur_nonsec),
        .s_d_o   (ctl_s_new),
        .ns_d_o  (ctl_ns_new)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_fault = req_valid && g_fault;
        st_d.rsp_wr_ok = req_valid && g_wr_ok;
        st_d.rsp_rdata = '0;
        if (req_valid && !g_fault && !req_write) begin
            st_d.rsp_rdata = (sel == SEL_CTL) ? ctl_view : st_q.aux;
        end
        if (req_valid && g_wr_ok) begin
            if (sel == SEL_CTL) begin
                st_d.ctl_s  = ctl_s_new;
                st_d.ctl_ns = ctl_ns_new;
            end else begin
                st_d.aux = (st_q.aux & AUX_RO_MASK) | (req_wdata & ~AUX_RO_MASK);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl_s     <= CTL_RESET;
            st_q.ctl_ns    <= CTL_RESET;
            st_q.aux       <= AUX_RESET;
            st_q.rsp_valid <= 1'b0;
            st_q.rsp_fault <= 1'b0;
            st_q.rsp_wr_ok <= 1'b0;
            st_q.rsp_rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_fault    = st_q.rsp_fault;
    assign rsp_wr_ok    = st_q.rsp_wr_ok;
    assign rsp_rdata    = st_q.rsp_rdata;
    assign en_translate = ctl_view[BIT_TRANSLATE];
    assign en_align     = ctl_view[BIT_ALIGN];
    assign en_dcache    = ctl_view[BIT_DCACHE];

    // R1: user-mode access faults and leaves all storage alone
    p_user_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cur_priv) |=> (rsp_fault && !rsp_wr_ok &&
            $stable(st_q.ctl_s) && $stable(st_q.ctl_ns) && $stable(st_q.aux)));

    // R2: locked secure control write faults, storage unchanged
    p_sec_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_sel && cur_priv && !cur_nonsec && sec_disable)
        |=> (rsp_fault && $stable(st_q.ctl_s) && $stable(st_q.ctl_ns)));

    // R3: non-secure control writes never reach secure-only bits
    p_ns_smo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_sel && cur_priv && cur_nonsec)
        |=> (rsp_wr_ok && $stable(st_q.ctl_s & CTL_SMO_MASK)));

    // R5: fixed bits never move
    p_ro_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(st_q.ctl_s & CTL_RO_MASK) && $stable(st_q.ctl_ns & CTL_RO_MASK) &&
        $stable(st_q.aux & AUX_RO_MASK));

    // R9: locked non-secure auxiliary write is silently dropped
    p_aux_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel && cur_priv && cur_nonsec && !ns_aux_allow)
        |=> (!rsp_fault && !rsp_wr_ok && $stable(st_q.aux)));

    // R10: one response per request, flags only on the response
    p_resp_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_resp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_flag_in_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_wr_ok) |-> rsp_valid);
endmodule

// File: tb/test_sysctl_bank.sv
module test_sysctl_bank;
    localparam int unsigned   DW      = 32;
    localparam logic [31:0]   BANK    = 32'h0000_0007;
    localparam logic [31:0]   SMO     = 32'h0000_2100;
    localparam logic [31:0]   RO      = 32'h0000_0078;
    localparam logic [31:0]   CRST    = 32'h0000_0050;
    localparam logic [31:0]   ARO     = 32'hFFFF_FF80;
    localparam logic [31:0]   ARST    = 32'h0000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_sel = 1'b0, req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          cur_priv = 1'b0, cur_nonsec = 1'b0, sec_disable = 1'b0, ns_aux_allow = 1'b0;
    logic          rsp_valid, rsp_wr_ok, rsp_fault;
    logic [DW-1:0] rsp_rdata;
    logic          en_translate, en_align, en_dcache;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m_s = CRST, m_ns = CRST, m_aux = ARST;

    always #4 clk = ~clk;

    sysctl_bank #(.DW(DW), .CTL_BANK_MASK(BANK), .CTL_SMO_MASK(SMO), .CTL_RO_MASK(RO),
                  .CTL_RESET(CRST), .AUX_RO_MASK(ARO), .AUX_RESET(ARST)) i_sysctl_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_write(req_write), .req_wdata(req_wdata), .cur_priv(cur_priv),
        .cur_nonsec(cur_nonsec), .sec_disable(sec_disable), .ns_aux_allow(ns_aux_allow),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_wr_ok(rsp_wr_ok),
        .rsp_fault(rsp_fault), .en_translate(en_translate), .en_align(en_align),
        .en_dcache(en_dcache));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_view(logic ns);
        logic [31:0] bsel = BANK & ~SMO;
        return ns ? ((m_ns & bsel) | (m_s & ~bsel)) : m_s;
    endfunction

    // one access; returns response sampled at the negedge after the capturing edge
    task automatic access(logic sel, logic wr, logic [31:0] d, logic p, logic ns,
                          output logic flt, output logic ok, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_write = wr; req_wdata = d;
        cur_priv = p; cur_nonsec = ns;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 strobe", {31'b0, rsp_valid}, 32'd1);
        flt = rsp_fault; ok = rsp_wr_ok; rd = rsp_rdata;
    endtask

    function automatic void model_write(logic sel, logic [31:0] d, logic ns);
        logic [31:0] wm = ~RO & ~SMO;
        if (sel) m_aux = (m_aux & ARO) | (d & ~ARO);
        else if (!ns) m_s = (m_s & RO) | (d & ~RO);
        else begin
            m_ns = (m_ns & ~(wm & BANK)) | (d & wm & BANK);
            m_s  = (m_s & ~(wm & ~BANK)) | (d & wm & ~BANK);
        end
    endfunction

    task automatic read_both(string req);
        logic f, o; logic [31:0] r;
        access(1'b0, 1'b0, '0, 1'b1, 1'b0, f, o, r);
        chk({req, " secure view"}, r, model_view(1'b0));
        access(1'b0, 1'b0, '0, 1'b1, 1'b1, f, o, r);
        chk({req, " non-secure view"}, r, model_view(1'b1));
    endtask

    task automatic t_reset;
        logic f, o; logic [31:0] r;
        chk("R10 idle after reset", {30'b0, rsp_valid, rsp_fault}, 32'd0);
        chk("R6 enables reset", {29'b0, en_dcache, en_align, en_translate}, 32'd0);
        read_both("R11 reset");
        access(1'b1, 1'b0, '0, 1'b1, 1'b1, f, o, r);
        chk("R11 aux reset", r, ARST);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 8; i++) begin
            logic p = i[2], ns = i[1], dis = i[0];
            logic f, o, ef; logic [31:0] r, d;
            d = 32'h1357_9BDF * (i + 3);
            sec_disable = dis;
            ef = !p || (!ns && dis);
            access(1'b0, 1'b1, d, p, ns, f, o, r);
            chk(ef ? (p ? "R2 lock fault" : "R1 user fault") : "R3 accepted fault", {31'b0, f}, {31'b0, ef});
            chk("R1 R2 R3 wr_ok", {31'b0, o}, {31'b0, !ef});
            chk("R11 write rdata", r, 32'd0);
            if (!ef) model_write(1'b0, d, ns);
            sec_disable = 1'b0;
            read_both("R5 R6 sweep");
            sec_disable = dis;
            access(1'b0, 1'b0, '0, p, ns, f, o, r);
            chk("R1 R2 read fault", {31'b0, f}, {31'b0, !p});
            sec_disable = 1'b0;
        end
    endtask

    task automatic t_ns_filter;
        logic f, o; logic [31:0] r;
        access(1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, f, o, r); model_write(1'b0, 32'h0, 1'b0);
        access(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, f, o, r); model_write(1'b0, 32'hFFFF_FFFF, 1'b1);
        chk("R3 ns write ok", {31'b0, o}, 32'd1);
        access(1'b0, 1'b0, '0, 1'b1, 1'b1, f, o, r);
        chk("R3 R4 smo bits stay 0", r & SMO, 32'd0);
        chk("R3 other bits set", r & ~SMO & ~RO, 32'hFFFF_FFFF & ~SMO & ~RO);
        chk("R5 ro bits", r & RO, CRST & RO);
        access(1'b0, 1'b1, SMO, 1'b1, 1'b0, f, o, r); model_write(1'b0, SMO, 1'b0);
        access(1'b0, 1'b0, '0, 1'b1, 1'b1, f, o, r);
        chk("R4 ns reads secure smo", r & SMO, SMO);
        read_both("R6 after filter");
    endtask

    task automatic t_enables;
        logic f, o; logic [31:0] r;
        access(1'b0, 1'b1, 32'h5, 1'b1, 1'b0, f, o, r); model_write(1'b0, 32'h5, 1'b0);
        access(1'b0, 1'b1, 32'h2, 1'b1, 1'b1, f, o, r); model_write(1'b0, 32'h2, 1'b1);
        cur_nonsec = 1'b0; #1;
        chk("R7 secure enables", {29'b0, en_dcache, en_align, en_translate}, 32'h5);
        cur_nonsec = 1'b1; #1;
        chk("R7 non-secure enables", {29'b0, en_dcache, en_align, en_translate}, 32'h2);
        cur_nonsec = 1'b0; #1;
        chk("R7 back to secure", {29'b0, en_dcache, en_align, en_translate}, 32'h5);
        read_both("R6 banks independent");
    endtask

    task automatic t_aux;
        logic f, o; logic [31:0] r;
        access(1'b1, 1'b1, 32'hFFFF_FF35, 1'b1, 1'b0, f, o, r); model_write(1'b1, 32'hFFFF_FF35, 1'b0);
        chk("R8 secure aux ok", {30'b0, f, o}, 32'd1);
        access(1'b1, 1'b0, '0, 1'b1, 1'b1, f, o, r);
        chk("R8 shared aux read", r, m_aux);
        ns_aux_allow = 1'b0;
        access(1'b1, 1'b1, 32'h0000_004A, 1'b1, 1'b1, f, o, r);
        chk("R9 locked aux no fault no ok", {30'b0, f, o}, 32'd0);
        access(1'b1, 1'b0, '0, 1'b1, 1'b0, f, o, r);
        chk("R9 locked aux unchanged", r, m_aux);
        ns_aux_allow = 1'b1;
        access(1'b1, 1'b1, 32'h0000_004A, 1'b1, 1'b1, f, o, r); model_write(1'b1, 32'h4A, 1'b1);
        chk("R9 allowed aux ok", {30'b0, f, o}, 32'd1);
        access(1'b1, 1'b0, '0, 1'b1, 1'b0, f, o, r);
        chk("R9 allowed aux value", r, m_aux);
        access(1'b1, 1'b1, 32'h0, 1'b0, 1'b0, f, o, r);
        chk("R1 user aux fault", {30'b0, f, o}, 32'd2);
        access(1'b1, 1'b0, '0, 1'b1, 1'b0, f, o, r);
        chk("R1 aux unchanged", r, m_aux);
        ns_aux_allow = 1'b0;
    endtask

    task automatic t_strobe;
        logic f, o; logic [31:0] r;
        access(1'b0, 1'b0, '0, 1'b0, 1'b0, f, o, r);
        chk("R10 fault with strobe", {31'b0, f}, 32'd1);
        @(negedge clk);
        chk("R10 single cycle", {30'b0, rsp_valid, rsp_fault}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_sweep;
        t_ns_filter;
        t_enables;
        t_aux;
        t_strobe;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=running exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule